// File: doc/BRIEF.md
# Interrupt Source Controller

This block owns a table of interrupt sources. Each entry holds a target server number, a live priority, a saved priority and a few status flags. A parameter fixes each source as either level type or message type. Per-source input lines are sampled on the clock. Offers go out through a single-entry valid/ready port that carries the server, the global source number and the priority. The presentation side sends back reject, end-of-interrupt and resend strobes. A configuration port lets firmware set, read, disable and re-enable an entry.

Global source numbers run from a base offset `BASE` up to `BASE+NSRC-1`. Priority 0xFF masks a source. Interrupts that are rejected or that arrive while masked are remembered. A resend request replays them by scanning the table, one source per cycle. The scan pauses while any offer is still waiting or the output holds an unaccepted offer, so events from the lines always go out ahead of it.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset no offer is valid, every entry reads back server 0 and priority 0xFF, and all status flags are clear. The level or message type of each source does not change.
- R2: A configuration request is answered one cycle later with `cfg_ack`. A source number below `BASE`, or at or above `BASE+NSRC`, raises `cfg_err` and changes nothing. A reject or end-of-interrupt with such a number is ignored.
- R3: A set (cfg_op 0) is refused with `cfg_err` when the server is not below `NSERVERS` or when the 9-bit priority is above 0xFF. The entry is left unchanged.
- R4: A set stores the server and priority and also copies the priority into the saved priority. A read (cfg_op 1) returns the server and live priority. Every accepted request returns the entry's contents after the operation on `cfg_rd_server`/`cfg_rd_prio`.
- R5: A message source fires on a rising edge of its line. If it is unmasked, it is offered with its server, number `BASE+index` and priority, and the offer is valid on the cycle after the edge was sampled. If it is masked, a pending flag is set instead, and the source is offered once a set or enable unmasks it.
- R6: A level source tracks its line. Whenever the line changes, or a set, enable or scan reaches the entry, the source is offered if it is unmasked, its line is high and its sent flag is clear. Offering it sets the sent flag.
- R7: End-of-interrupt clears the sent flag of a level source and offers nothing by itself. It has no effect on a message source.
- R8: A reject marks the source rejected and clears its sent flag. A resend starts a scan from index 0. The scan clears the rejected flag of a message source and re-offers the source if it is unmasked. It re-evaluates a level source by the R6 rule. A resend that arrives while a scan is running is ignored.
- R9: Disable (cfg_op 2) saves the live priority and sets the priority to 0xFF. Enable (cfg_op 3) copies the saved priority back. A configuration change that masks a source with an offer still queued cancels that offer: a message source becomes masked-pending, and a level source gets its sent flag cleared.
- R10: An offer holds steady while `off_ready` is low. Queued offers leave lowest index first, at most one per accepted slot. The scan advances only when no offer is queued and the output is empty.
- R11: An offer never carries priority 0xFF and never carries a number outside the valid range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_line | input | NSRC | Per-source interrupt lines |
| cfg_valid | input | 1 | Configuration request strobe |
| cfg_op | input | 2 | 0 set, 1 read, 2 disable, 3 enable |
| cfg_num | input | NUM_W | Global source number |
| cfg_server | input | SRV_W | Target server for set |
| cfg_prio | input | 9 | Priority for set (values above 0xFF are refused) |
| cfg_ack | output | 1 | Response valid |
| cfg_err | output | 1 | Parameter error |
| cfg_rd_server | output | SRV_W | Entry server after the operation |
| cfg_rd_prio | output | 8 | Entry priority after the operation |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Rejected source number |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Completed source number |
| resend_req | input | 1 | Start a resend scan |
| off_valid | output | 1 | Offer valid |
| off_ready | input | 1 | Offer accepted |
| off_server | output | SRV_W | Offer target server |
| off_num | output | NUM_W | Offer global source number |
| off_prio | output | 8 | Offer priority |

## Verification
The bench targets the following failure modes:
- A level source that re-fires right after a reject or an end-of-interrupt, without a new line event or scan, shows up as an extra offer.
- A message edge that arrives while the source is masked, and is lost, shows up as a missing offer when the source is enabled.
- A disable/enable pair that does not restore the saved priority shows up as a wrong readback value or a wrong offer priority.
- Holding off `off_ready` while two lines fire together checks that the output holds steady and that the lower index leaves first.
- A resend is issued with rejected sources of both types, to check that only flagged message sources and still-asserted, unsent level sources come back.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef enum logic [1:0] {
    OP_SET = 2'd0,
    OP_GET = 2'd1,
    OP_OFF = 2'd2,
    OP_ON  = 2'd3
  } cfg_op_e;

  localparam logic [7:0] PRIO_MASKED = 8'hFF;
endpackage

// File: rtl/irq_src_lines.sv
module irq_src_lines #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_in,
  output logic [N-1:0] line_q,
  output logic [N-1:0] rise,
  output logic [N-1:0] chg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_in;
  end

  assign rise = line_in & ~line_q;
  assign chg  = line_in ^ line_q;
endmodule

// File: rtl/irq_src_pick.sv
module irq_src_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_src_offer.sv
module irq_src_offer #(
  parameter int SRV_W = 3,
  parameter int NUM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SRV_W-1:0] ld_server,
  input  logic [NUM_W-1:0] ld_num,
  input  logic [7:0]       ld_prio,
  output logic             can_load,
  input  logic             off_ready,
  output logic             off_valid,
  output logic [SRV_W-1:0] off_server,
  output logic [NUM_W-1:0] off_num,
  output logic [7:0]       off_prio
);
  logic valid_d;

  assign can_load = !off_valid || off_ready;

  always_comb begin
    valid_d = off_valid;
    if (can_load) valid_d = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_valid  <= 1'b0;
      off_server <= '0;
      off_num    <= '0;
      off_prio   <= '0;
    end else begin
      off_valid <= valid_d;
      if (load && can_load) begin
        off_server <= ld_server;
        off_num    <= ld_num;
        off_prio   <= ld_prio;
      end
    end
  end

  // R10: a stalled offer keeps its contents
  p_offer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid && !off_ready |=> off_valid && $stable(off_num) && $stable(off_prio)
                               && $stable(off_server));
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int NUM_W    = 12,
  parameter int BASE     = 32,
  parameter int SRV_W    = 3,
  parameter int NSERVERS = 6,
  parameter logic [NSRC-1:0] LEVEL_MASK = {NSRC{1'b1}} << (NSRC / 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_line,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_op,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [8:0]       cfg_prio,
  output logic             cfg_ack,
  output logic             cfg_err,
  output logic [SRV_W-1:0] cfg_rd_server,
  output logic [7:0]       cfg_rd_prio,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend_req,
  output logic             off_valid,
  input  logic             off_ready,
  output logic [SRV_W-1:0] off_server,
  output logic [NUM_W-1:0] off_num,
  output logic [7:0]       off_prio
);
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] LAST_N = NUM_W'(BASE + NSRC);
  localparam logic [SRV_W:0]   SRV_LIM = (SRV_W+1)'(NSERVERS);

  function automatic logic in_rng(input logic [NUM_W-1:0] n);
    return (n >= BASE_N) && (n < LAST_N);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [NUM_W-1:0] n);
    return IDX_W'(n - BASE_N);
  endfunction

  // Entry table and status flags
  logic [7:0]       prio_q [NSRC];
  logic [7:0]       save_q [NSRC];
  logic [SRV_W-1:0] srv_q  [NSRC];
  logic [7:0]       prio_d [NSRC];
  logic [7:0]       save_d [NSRC];
  logic [SRV_W-1:0] srv_d  [NSRC];
  logic [NSRC-1:0]  rej_q, sent_q, mp_q, qd_q;
  logic [NSRC-1:0]  rej_d, sent_d, mp_d, qd_pre, qd_d;
  logic             scan_act_q, scan_act_d;
  logic [IDX_W-1:0] scan_ptr_q, scan_ptr_d;

  logic [NSRC-1:0]  line_q, rise, chg;
  logic             cerr;
  logic [IDX_W-1:0] cidx;
  logic [SRV_W-1:0] rd_srv_d;
  logic [7:0]       rd_prio_d;
  logic             pk_found, can_load, load;
  logic [IDX_W-1:0] pk_idx;
  cfg_op_e          op;

  irq_src_lines #(.N(NSRC)) u_lines (
    .clk(clk), .rst_n(rst_n), .line_in(src_line),
    .line_q(line_q), .rise(rise), .chg(chg)
  );

  assign op   = cfg_op_e'(cfg_op);
  assign cidx = to_idx(cfg_num);
  assign cerr = !in_rng(cfg_num) ||
                (op == OP_SET && (({1'b0, cfg_server} >= SRV_LIM) || cfg_prio[8]));

  // Event processing: config, reject, eoi, lines, scan (drain follows)
  always_comb begin
    logic step;
    prio_d = prio_q; save_d = save_q; srv_d = srv_q;
    rej_d = rej_q; sent_d = sent_q; mp_d = mp_q; qd_pre = qd_q;
    scan_act_d = scan_act_q; scan_ptr_d = scan_ptr_q;

    if (cfg_valid && !cerr) begin
      unique case (op)
        OP_SET: begin
          srv_d[cidx]  = cfg_server;
          prio_d[cidx] = cfg_prio[7:0];
          save_d[cidx] = cfg_prio[7:0];
        end
        OP_OFF: begin
          save_d[cidx] = prio_q[cidx];
          prio_d[cidx] = PRIO_MASKED;
        end
        OP_ON:   prio_d[cidx] = save_q[cidx];
        default: ;
      endcase
      if (op != OP_GET) begin
        if (prio_d[cidx] == PRIO_MASKED && qd_pre[cidx]) begin
          qd_pre[cidx] = 1'b0;
          if (LEVEL_MASK[cidx]) sent_d[cidx] = 1'b0;
          else                  mp_d[cidx]   = 1'b1;
        end
        if (LEVEL_MASK[cidx]) begin
          if (prio_d[cidx] != PRIO_MASKED && line_q[cidx] && !sent_d[cidx]) begin
            sent_d[cidx] = 1'b1;
            qd_pre[cidx] = 1'b1;
          end
        end else if (mp_d[cidx] && prio_d[cidx] != PRIO_MASKED) begin
          mp_d[cidx]   = 1'b0;
          qd_pre[cidx] = 1'b1;
        end
      end
    end
    rd_srv_d  = srv_d[cidx];
    rd_prio_d = prio_d[cidx];

    if (rej_valid && in_rng(rej_num)) begin
      rej_d[to_idx(rej_num)]  = 1'b1;
      sent_d[to_idx(rej_num)] = 1'b0;
    end
    if (eoi_valid && in_rng(eoi_num) && LEVEL_MASK[to_idx(eoi_num)])
      sent_d[to_idx(eoi_num)] = 1'b0;

    for (int i = 0; i < NSRC; i++) begin
      if (LEVEL_MASK[i]) begin
        if (chg[i] && src_line[i] && prio_d[i] != PRIO_MASKED && !sent_d[i]) begin
          sent_d[i] = 1'b1;
          qd_pre[i] = 1'b1;
        end
      end else if (rise[i]) begin
        if (prio_d[i] == PRIO_MASKED) mp_d[i]   = 1'b1;
        else                          qd_pre[i] = 1'b1;
      end
    end

    step = scan_act_q && (qd_pre == '0) && !off_valid;
    if (step) begin
      if (LEVEL_MASK[scan_ptr_q]) begin
        if (prio_d[scan_ptr_q] != PRIO_MASKED && src_line[scan_ptr_q] &&
            !sent_d[scan_ptr_q]) begin
          sent_d[scan_ptr_q] = 1'b1;
          qd_pre[scan_ptr_q] = 1'b1;
        end
      end else if (rej_d[scan_ptr_q]) begin
        rej_d[scan_ptr_q] = 1'b0;
        if (prio_d[scan_ptr_q] != PRIO_MASKED) qd_pre[scan_ptr_q] = 1'b1;
      end
      scan_ptr_d = scan_ptr_q + 1'b1;
      if (scan_ptr_q == IDX_W'(NSRC - 1)) scan_act_d = 1'b0;
    end
    if (resend_req && !scan_act_q) begin
      scan_act_d = 1'b1;
      scan_ptr_d = '0;
    end
  end

  irq_src_pick #(.N(NSRC)) u_pick (.req(qd_pre), .found(pk_found), .idx(pk_idx));

  assign load = pk_found && can_load;
  assign qd_d = qd_pre & ~(load ? (NSRC'(1) << pk_idx) : '0);

  irq_src_offer #(.SRV_W(SRV_W), .NUM_W(NUM_W)) u_offer (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_server(srv_d[pk_idx]), .ld_num(BASE_N + NUM_W'(pk_idx)),
    .ld_prio(prio_d[pk_idx]), .can_load(can_load), .off_ready(off_ready),
    .off_valid(off_valid), .off_server(off_server), .off_num(off_num),
    .off_prio(off_prio)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= PRIO_MASKED;
        save_q[i] <= PRIO_MASKED;
        srv_q[i]  <= '0;
      end
      rej_q <= '0; sent_q <= '0; mp_q <= '0; qd_q <= '0;
      scan_act_q <= 1'b0; scan_ptr_q <= '0;
      cfg_ack <= 1'b0; cfg_err <= 1'b0;
      cfg_rd_server <= '0; cfg_rd_prio <= '0;
    end else begin
      prio_q <= prio_d; save_q <= save_d; srv_q <= srv_d;
      rej_q <= rej_d; sent_q <= sent_d; mp_q <= mp_d; qd_q <= qd_d;
      scan_act_q <= scan_act_d; scan_ptr_q <= scan_ptr_d;
      cfg_ack <= cfg_valid;
      if (cfg_valid) begin
        cfg_err       <= cerr;
        cfg_rd_server <= cerr ? '0 : rd_srv_d;
        cfg_rd_prio   <= cerr ? '0 : rd_prio_d;
      end
    end
  end

  // R4: every request is answered on the next cycle
  p_cfg_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_ack);
  // R3: an over-range priority on a set is refused
  p_bad_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_op == 2'd0 && cfg_prio[8] |=> cfg_err);
  // R2: an out-of-range number is refused
  p_bad_num_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !in_rng(cfg_num) |=> cfg_err);
  // R11: offers are unmasked and in range
  p_offer_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    off_valid |-> off_prio != PRIO_MASKED && in_rng(off_num));
  // R10: scan does not move while the output is occupied
  p_scan_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_act_q && off_valid |=> $stable(scan_ptr_q));
endmodule

// File: tb/irq_src_ctrl_bench.sv
module irq_src_ctrl_bench;
  localparam int N = 16;
  localparam int BASE = 32;
  localparam int NSRV = 6;
  localparam logic [N-1:0] LVL = 16'hFF00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_line = '0;
  logic cfg_valid = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [11:0] cfg_num = '0;
  logic [2:0] cfg_server = '0;
  logic [8:0] cfg_prio = '0;
  logic cfg_ack, cfg_err;
  logic [2:0] cfg_rd_server;
  logic [7:0] cfg_rd_prio;
  logic rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0, off_ready = 1'b1;
  logic [11:0] rej_num = '0, eoi_num = '0;
  logic off_valid;
  logic [2:0] off_server;
  logic [11:0] off_num;
  logic [7:0] off_prio;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  irq_src_ctrl u_irq_src_ctrl (
    .clk(clk), .rst_n(rst_n), .src_line(src_line), .cfg_valid(cfg_valid),
    .cfg_op(cfg_op), .cfg_num(cfg_num), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err), .cfg_rd_server(cfg_rd_server),
    .cfg_rd_prio(cfg_rd_prio), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend_req(resend_req),
    .off_valid(off_valid), .off_ready(off_ready), .off_server(off_server),
    .off_num(off_num), .off_prio(off_prio)
  );

  // Behavioural reference model
  int m_prio[N], m_save[N], m_srv[N];
  bit m_rej[N], m_sent[N], m_mp[N], m_qd[N], m_lq[N];
  bit m_act; int m_ptr;
  bit m_ov; int m_osrv, m_onum, m_oprio;
  bit m_ack, m_err; int m_rsrv, m_rprio;

  function automatic bit ok_num(int n);
    return n >= BASE && n < BASE + N;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_prio[i] = 255; m_save[i] = 255; m_srv[i] = 0;
        m_rej[i] = 0; m_sent[i] = 0; m_mp[i] = 0; m_qd[i] = 0; m_lq[i] = 0;
      end
      m_act = 0; m_ptr = 0; m_ov = 0; m_osrv = 0; m_onum = 0; m_oprio = 0;
      m_ack = 0; m_err = 0; m_rsrv = 0; m_rprio = 0;
    end else begin
      bit ov_old, act_old, bad, anyq;
      int c;
      ov_old = m_ov; act_old = m_act;
      m_ack = cfg_valid;
      if (cfg_valid) begin
        c = int'(cfg_num) - BASE;
        bad = !ok_num(int'(cfg_num)) ||
              (cfg_op == 0 && (int'(cfg_server) >= NSRV || cfg_prio > 255));
        m_err = bad;
        if (!bad) begin
          if (cfg_op == 0) begin
            m_srv[c] = cfg_server; m_prio[c] = cfg_prio; m_save[c] = cfg_prio;
          end else if (cfg_op == 2) begin
            m_save[c] = m_prio[c]; m_prio[c] = 255;
          end else if (cfg_op == 3) m_prio[c] = m_save[c];
          if (cfg_op != 1) begin
            if (m_prio[c] == 255 && m_qd[c]) begin
              m_qd[c] = 0;
              if (LVL[c]) m_sent[c] = 0; else m_mp[c] = 1;
            end
            if (LVL[c]) begin
              if (m_prio[c] != 255 && m_lq[c] && !m_sent[c]) begin
                m_sent[c] = 1; m_qd[c] = 1;
              end
            end else if (m_mp[c] && m_prio[c] != 255) begin
              m_mp[c] = 0; m_qd[c] = 1;
            end
          end
          m_rsrv = m_srv[c]; m_rprio = m_prio[c];
        end else begin
          m_rsrv = 0; m_rprio = 0;
        end
      end
      if (rej_valid && ok_num(int'(rej_num))) begin
        m_rej[int'(rej_num) - BASE] = 1; m_sent[int'(rej_num) - BASE] = 0;
      end
      if (eoi_valid && ok_num(int'(eoi_num)) && LVL[int'(eoi_num) - BASE])
        m_sent[int'(eoi_num) - BASE] = 0;
      for (int i = 0; i < N; i++) begin
        if (LVL[i]) begin
          if (src_line[i] != m_lq[i] && src_line[i] && m_prio[i] != 255 && !m_sent[i]) begin
            m_sent[i] = 1; m_qd[i] = 1;
          end
        end else if (src_line[i] && !m_lq[i]) begin
          if (m_prio[i] == 255) m_mp[i] = 1; else m_qd[i] = 1;
        end
      end
      anyq = 0;
      for (int i = 0; i < N; i++) anyq |= m_qd[i];
      if (m_act && !anyq && !ov_old) begin
        if (LVL[m_ptr]) begin
          if (m_prio[m_ptr] != 255 && src_line[m_ptr] && !m_sent[m_ptr]) begin
            m_sent[m_ptr] = 1; m_qd[m_ptr] = 1;
          end
        end else if (m_rej[m_ptr]) begin
          m_rej[m_ptr] = 0;
          if (m_prio[m_ptr] != 255) m_qd[m_ptr] = 1;
        end
        if (m_ptr == N - 1) begin m_act = 0; m_ptr = 0; end
        else m_ptr++;
      end
      if (resend_req && !act_old) begin m_act = 1; m_ptr = 0; end
      if (!ov_old || off_ready) begin
        m_ov = 0;
        for (int i = 0; i < N; i++) begin
          if (m_qd[i] && !m_ov) begin
            m_ov = 1; m_qd[i] = 0;
            m_osrv = m_srv[i]; m_onum = BASE + i; m_oprio = m_prio[i];
          end
        end
      end
      for (int i = 0; i < N; i++) m_lq[i] = src_line[i];
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (off_valid !== m_ov || (m_ov && (int'(off_num) != m_onum ||
          int'(off_prio) != m_oprio || int'(off_server) != m_osrv))) begin
        fails++;
        $display("FAIL %s offer: got v=%0b num=%0d prio=%0d srv=%0d exp v=%0b num=%0d prio=%0d srv=%0d",
                 cur_req, off_valid, off_num, off_prio, off_server, m_ov, m_onum, m_oprio, m_osrv);
      end
      checks++;
      if (cfg_ack !== m_ack || (m_ack && (cfg_err !== m_err ||
          int'(cfg_rd_prio) != m_rprio || int'(cfg_rd_server) != m_rsrv))) begin
        fails++;
        $display("FAIL %s cfg: got ack=%0b err=%0b srv=%0d prio=%0d exp ack=%0b err=%0b srv=%0d prio=%0d",
                 cur_req, cfg_ack, cfg_err, cfg_rd_server, cfg_rd_prio, m_ack, m_err, m_rsrv, m_rprio);
      end
    end
  end

  task automatic chk(input bit cond, input string what, input int got, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, got, exp);
    end
  endtask

  task automatic cfg(input int op, input int num, input int srv, input int prio);
    cfg_valid = 1; cfg_op = 2'(op); cfg_num = 12'(num);
    cfg_server = 3'(srv); cfg_prio = 9'(prio);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic cfg_expect(input int op, input int num, input int srv, input int prio,
                            input bit e_err, input int e_srv, input int e_prio);
    cfg(op, num, srv, prio);
    chk(cfg_ack && cfg_err == e_err, "cfg error flag", int'(cfg_err), int'(e_err));
    if (!e_err) begin
      chk(int'(cfg_rd_prio) == e_prio, "readback priority", int'(cfg_rd_prio), e_prio);
      chk(int'(cfg_rd_server) == e_srv, "readback server", int'(cfg_rd_server), e_srv);
    end
  endtask

  task automatic wait_offer(input int num, input int prio);
    bit seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (off_valid) seen = 1; else @(negedge clk);
    end
    chk(seen && int'(off_num) == num, "offer number", int'(off_num), num);
    chk(seen && int'(off_prio) == prio, "offer priority", int'(off_prio), prio);
    @(negedge clk);
  endtask

  task automatic expect_quiet(input int n);
    bit any = 0;
    for (int k = 0; k < n; k++) begin
      if (off_valid) any = 1;
      @(negedge clk);
    end
    chk(!any, "unexpected offer", int'(any), 0);
  endtask

  task automatic pulse(input int i);
    src_line[i] = 1; @(negedge clk); src_line[i] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(!off_valid, "offer after reset", int'(off_valid), 0);
    cfg_expect(1, BASE + 9, 0, 0, 0, 0, 255);
    cfg_expect(1, BASE + 0, 0, 0, 0, 0, 255);

    cur_req = "R2";
    cfg_expect(1, BASE - 1, 0, 0, 1, 0, 0);
    cfg_expect(0, BASE + N, 1, 4, 1, 0, 0);

    cur_req = "R3";
    cfg_expect(0, BASE + 1, NSRV, 5, 1, 0, 0);
    cfg_expect(0, BASE + 1, 2, 256, 1, 0, 0);
    cfg_expect(1, BASE + 1, 0, 0, 0, 0, 255);

    cur_req = "R4";
    cfg_expect(0, BASE + 1, 2, 5, 0, 2, 5);
    cfg_expect(0, BASE + 3, 4, 9, 0, 4, 9);
    cfg_expect(1, BASE + 1, 0, 0, 0, 2, 5);

    cur_req = "R5";
    pulse(1);
    wait_offer(BASE + 1, 5);
    pulse(2);
    expect_quiet(4);
    cfg(0, BASE + 2, 1, 3);
    wait_offer(BASE + 2, 3);

    cur_req = "R6";
    cfg(0, BASE + 8, 1, 4);
    src_line[8] = 1;
    wait_offer(BASE + 8, 4);
    src_line[8] = 0; @(negedge clk); src_line[8] = 1;
    expect_quiet(4);

    cur_req = "R7";
    eoi_valid = 1; eoi_num = 12'(BASE + 8); @(negedge clk); eoi_valid = 0;
    expect_quiet(3);
    src_line[8] = 0; @(negedge clk); src_line[8] = 1;
    wait_offer(BASE + 8, 4);
    eoi_valid = 1; eoi_num = 12'(BASE + 1); @(negedge clk); eoi_valid = 0;
    expect_quiet(3);

    cur_req = "R8";
    rej_valid = 1; rej_num = 12'(BASE + 1); @(negedge clk);
    rej_num = 12'(BASE + 8); @(negedge clk); rej_valid = 0;
    expect_quiet(3);
    resend_req = 1; @(negedge clk); resend_req = 0;
    wait_offer(BASE + 1, 5);
    wait_offer(BASE + 8, 4);
    repeat (20) @(negedge clk);
    resend_req = 1; @(negedge clk); resend_req = 0;
    expect_quiet(24);

    cur_req = "R9";
    cfg_expect(2, BASE + 1, 0, 0, 0, 2, 255);
    pulse(1);
    expect_quiet(4);
    cfg_expect(3, BASE + 1, 0, 0, 0, 2, 5);
    wait_offer(BASE + 1, 5);

    cur_req = "R10";
    off_ready = 0;
    src_line[1] = 1; src_line[3] = 1; @(negedge clk);
    src_line[1] = 0; src_line[3] = 0;
    repeat (4) @(negedge clk);
    chk(off_valid && int'(off_num) == BASE + 1, "held offer", int'(off_num), BASE + 1);
    off_ready = 1;
    @(negedge clk);
    chk(off_valid && int'(off_num) == BASE + 3, "second offer", int'(off_num), BASE + 3);
    off_ready = 0;
    src_line[3] = 1; @(negedge clk); src_line[3] = 0;
    cfg(2, BASE + 3, 0, 0);
    off_ready = 1;
    @(negedge clk);
    cur_req = "R9";
    expect_quiet(3);
    cfg(3, BASE + 3, 0, 0);
    wait_offer(BASE + 3, 9);

    cur_req = "R11";
    expect_quiet(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL %s watchdog expired: got 1 expected 0", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule